// File: doc/BRIEF.md
# Display Serial Link Transmitter

This block is the transmit end of a write-only serial link to a display panel. It accepts one parallel word at a time over a valid/ready handshake and shifts it out on a clock, a data line and a data/command line while it drives the chip select. Each word carries its own data-size code, wiring mode, data/command flag and clock-divider setting. All of these are captured together with the word when the handshake completes.

Three wiring modes are supported:
- **One-lane with prefix bit.** The data/command flag goes out as a leading prefix bit on the data line.
- **One-lane with separate flag line.** The flag line holds the data/command level for the whole frame.
- **Two-lane.** A shared prefix bit goes out on both lines at once. The lower half of the word then follows on the data line, and the upper half on the flag line.

The serial clock idles high. Data is launched on its falling edge and the panel samples it on the rising edge. When a further word is already waiting at the end of a frame, that word follows with no gap and with chip select held low.

Top module: `panel_ser_tx`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `cs_o` is 1 (with hardware chip select), `sck_o` is 1, `busy_o` is 0 and `word_ready_o` is 1.
- R2: With mode code 1 (one lane, prefix bit), the frame is len+1 clocks. The first bit on `mosi_o` is the captured `dc_i`. The data bits len-1 down to 0 follow, MSB first. `dcx_o` is 0 throughout the frame.
- R3: With mode code 2, and with the unused code 0 treated the same way, the frame is len clocks of data bits len-1 down to 0 on `mosi_o`, MSB first. `dcx_o` holds the captured `dc_i` for the whole frame.
- R4: With mode code 3 (two lanes), let h = len/2 (integer division). The first clock carries `dc_i` on both `mosi_o` and `dcx_o`. Then h clocks follow: bits h-1..0 go out on `mosi_o` and bits 2h-1..h on `dcx_o`, both MSB first. With a 9-bit length, bit 8 is dropped.
- R5: `size_i` holds len-1. Codes 0x07, 0x08, 0x0F, 0x11 and 0x17 give 8, 9, 16, 18 and 24 bits. Any other code gives 8 bits.
- R6: Word bits at position len and above have no effect on the serial output.
- R7: One half-period of `sck_o` is 2^`baud_i` clock cycles. The first falling edge of `sck_o` comes one half-period after the transfer starts. `sck_o` changes only at half-period boundaries.
- R8: With hardware chip select, `cs_o` falls in the cycle the transfer starts and rises one half-period after the last rising edge of `sck_o`. If a word is waiting at the end of a frame, that word follows at once with `cs_o` still low.
- R9: With `cs_soft_en_i`=1, `cs_o` equals `cs_soft_lvl_i`, and frames are sent exactly as in hardware mode.
- R10: `busy_o` rises in the cycle the transfer starts and falls when the transfer ends. With hardware chip select, `busy_o` equals the inverse of `cs_o`.
- R11: `mosi_o` and `dcx_o` change only at a falling edge of `sck_o` or in the cycle a transfer starts.
- R12: `word_ready_o` is 1 only when idle or in the final cycle of a frame's last half-period. The word, size, mode, flag and divider are captured at the accept, and later changes to those inputs do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | WORD_W | Right-aligned data word |
| word_valid_i | input | 1 | A word is offered |
| word_ready_o | output | 1 | The offered word is taken in this cycle |
| size_i | input | 5 | Frame length minus one |
| mode_i | input | 2 | Wiring mode code (1, 2, 3; 0 acts as 2) |
| dc_i | input | 1 | Data/command level for the word |
| baud_i | input | BAUD_W | Divider select, half-period 2^baud_i cycles |
| cs_soft_en_i | input | 1 | Select software chip-select level |
| cs_soft_lvl_i | input | 1 | Software chip-select level |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data line |
| dcx_o | output | 1 | Data/command line, or second data lane |
| cs_o | output | 1 | Chip select, active low |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions watch properties that must hold on every cycle:
- the clock stays high while idle and moves only on a divider tick;
- the data and flag lines move only at a launch edge or a start;
- the flag line is steady in separate-flag mode and low in prefix mode;
- hardware chip select mirrors busy;
- ready appears only when idle or at a frame's end.

The bench scenarios are needed for the content of the streams:
- the bit order in each wiring mode and length, including the fallback for unknown size codes;
- the masking of high word bits;
- the cycle distances between chip select, the first edge and the release for different divider values;
- the gap-free chaining of waiting words;
- the capture of settings at the accept while the inputs are changed mid-frame.

// File: rtl/panel_ser_pkg.sv
package panel_ser_pkg;

  localparam int MAX_W = 32;
  localparam int IDX_W = 5;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    LM_SPARE  = 2'd0,
    LM_A0_ONE = 2'd1,
    LM_DC_ONE = 2'd2,
    LM_DC_TWO = 2'd3
  } lane_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } seq_st_e;

  // Length in bits for a size code; unknown codes fall back to 8.
  function automatic idx_t frame_len(logic [4:0] code);
    idx_t len;
    case (code)
      5'h07:   len = 5'd8;
      5'h08:   len = 5'd9;
      5'h0F:   len = 5'd16;
      5'h11:   len = 5'd18;
      5'h17:   len = 5'd24;
      default: len = 5'd8;
    endcase
    return len;
  endfunction

  // Number of serial clocks a frame occupies.
  function automatic idx_t frame_bits(lane_mode_e m, idx_t len);
    idx_t n;
    case (m)
      LM_A0_ONE: n = len + 5'd1;
      LM_DC_TWO: n = (len >> 1) + 5'd1;
      default:   n = len;
    endcase
    return n;
  endfunction

  // Levels for {dcx, mosi} during serial clock k of a frame.
  function automatic logic [1:0] lane_bits(logic [MAX_W-1:0] w, lane_mode_e m,
                                           idx_t len, logic dc, idx_t k);
    idx_t h;
    idx_t lo_i;
    idx_t hi_i;
    idx_t pre_i;
    idx_t flat_i;
    logic mo;
    logic dx;
    h      = len >> 1;
    lo_i   = h - k;
    hi_i   = {h[IDX_W-2:0], 1'b0} - k;
    pre_i  = len - k;
    flat_i = len - 5'd1 - k;
    mo     = 1'b0;
    dx     = 1'b0;
    case (m)
      LM_A0_ONE: begin
        mo = (k == '0) ? dc : w[pre_i];
        dx = 1'b0;
      end
      LM_DC_TWO: begin
        if (k == '0) begin
          mo = dc;
          dx = dc;
        end else begin
          mo = w[lo_i];
          dx = w[hi_i];
        end
      end
      default: begin
        mo = w[flat_i];
        dx = dc;
      end
    endcase
    return {dx, mo};
  endfunction

endpackage

// File: rtl/panel_ser_div.sv
module panel_ser_div #(
  parameter int BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);

  localparam int CNT_W = 1 << BAUD_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = (CNT_W'(1) << baud_i) - CNT_W'(1);
  assign tick_o = run_i && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart_i || !run_i || tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/panel_ser_seq.sv
module panel_ser_seq
  import panel_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic valid_i,
  input  idx_t nbits_i,
  output logic ready_o,
  output logic accept_o,
  output logic shift_o,
  output logic last_o,
  output logic busy_o,
  output logic sck_o,
  output logic cs_o,
  output idx_t k_o
);

  seq_st_e st;
  logic    at_end;

  assign at_end   = (k_o == (nbits_i - idx_t'(1)));
  assign last_o   = (st == ST_HIGH) && tick_i && at_end;
  assign shift_o  = (st == ST_HIGH) && tick_i && !at_end;
  assign ready_o  = (st == ST_IDLE) || last_o;
  assign accept_o = ready_o && valid_i;
  assign busy_o   = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      k_o   <= '0;
      sck_o <= 1'b1;
      cs_o  <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept_o) begin
            st   <= ST_SETUP;
            k_o  <= '0;
            cs_o <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (tick_i) begin
            st    <= ST_LOW;
            sck_o <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            st    <= ST_HIGH;
            sck_o <= 1'b1;
          end
        end
        default: begin
          if (tick_i) begin
            if (!at_end) begin
              st    <= ST_LOW;
              k_o   <= k_o + idx_t'(1);
              sck_o <= 1'b0;
            end else if (accept_o) begin
              st    <= ST_LOW;
              k_o   <= '0;
              sck_o <= 1'b0;
            end else begin
              st   <= ST_IDLE;
              cs_o <= 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/panel_ser_lane.sv
module panel_ser_lane
  import panel_ser_pkg::*;
#(
  parameter int BAUD_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic                 shift_i,
  input  idx_t                 k_i,
  input  logic [MAX_W-1:0]     word_i,
  input  logic [4:0]           size_i,
  input  logic [1:0]           mode_i,
  input  logic                 dc_i,
  input  logic [BAUD_W-1:0]    baud_i,
  output idx_t                 nbits_o,
  output logic [BAUD_W-1:0]    baud_q_o,
  output lane_mode_e           mode_q_o,
  output logic                 mosi_o,
  output logic                 dcx_o
);

  logic [MAX_W-1:0] word_q;
  idx_t             len_q;
  logic             dc_q;
  idx_t             len_in;
  lane_mode_e       mode_in;
  logic [1:0]       first_pair;
  logic [1:0]       next_pair;

  assign len_in     = frame_len(size_i);
  assign mode_in    = lane_mode_e'(mode_i);
  assign first_pair = lane_bits(word_i, mode_in, len_in, dc_i, '0);
  assign next_pair  = lane_bits(word_q, mode_q_o, len_q, dc_q, k_i + idx_t'(1));
  assign nbits_o    = frame_bits(mode_q_o, len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      len_q    <= 5'd8;
      dc_q     <= 1'b0;
      mode_q_o <= LM_SPARE;
      baud_q_o <= '0;
      mosi_o   <= 1'b0;
      dcx_o    <= 1'b0;
    end else if (accept_i) begin
      word_q   <= word_i;
      len_q    <= len_in;
      dc_q     <= dc_i;
      mode_q_o <= mode_in;
      baud_q_o <= baud_i;
      {dcx_o, mosi_o} <= first_pair;
    end else if (shift_i) begin
      {dcx_o, mosi_o} <= next_pair;
    end
  end

endmodule

// File: rtl/panel_ser_tx.sv
module panel_ser_tx
  import panel_ser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [4:0]        size_i,
  input  logic [1:0]        mode_i,
  input  logic              dc_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              cs_soft_en_i,
  input  logic              cs_soft_lvl_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              dcx_o,
  output logic              cs_o,
  output logic              busy_o
);

  logic [MAX_W-1:0]  word_ext;
  logic              tick_w;
  logic              accept_w;
  logic              shift_w;
  logic              last_w;
  logic              cs_hw_w;
  idx_t              k_w;
  idx_t              nbits_w;
  logic [BAUD_W-1:0] baud_q_w;
  lane_mode_e        mode_q_w;

  if (WORD_W < MAX_W) begin : g_ext
    assign word_ext = {{(MAX_W-WORD_W){1'b0}}, word_i};
  end else begin : g_full
    assign word_ext = word_i[MAX_W-1:0];
  end

  panel_ser_div #(.BAUD_W(BAUD_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (busy_o),
    .restart_i (accept_w),
    .baud_i    (baud_q_w),
    .tick_o    (tick_w)
  );

  panel_ser_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_w),
    .valid_i  (word_valid_i),
    .nbits_i  (nbits_w),
    .ready_o  (word_ready_o),
    .accept_o (accept_w),
    .shift_o  (shift_w),
    .last_o   (last_w),
    .busy_o   (busy_o),
    .sck_o    (sck_o),
    .cs_o     (cs_hw_w),
    .k_o      (k_w)
  );

  panel_ser_lane #(.BAUD_W(BAUD_W)) u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .shift_i  (shift_w),
    .k_i      (k_w),
    .word_i   (word_ext),
    .size_i   (size_i),
    .mode_i   (mode_i),
    .dc_i     (dc_i),
    .baud_i   (baud_i),
    .nbits_o  (nbits_w),
    .baud_q_o (baud_q_w),
    .mode_q_o (mode_q_w),
    .mosi_o   (mosi_o),
    .dcx_o    (dcx_o)
  );

  assign cs_o = cs_soft_en_i ? cs_soft_lvl_i : cs_hw_w;

endmodule

// File: rtl/panel_ser_chk.sv
module panel_ser_chk
  import panel_ser_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       sck_o,
  input logic       cs_o,
  input logic       mosi_o,
  input logic       dcx_o,
  input logic       cs_soft_en_i,
  input logic       word_ready_o,
  input logic       tick_w,
  input logic       accept_w,
  input logic       shift_w,
  input logic       last_w,
  input lane_mode_e mode_q_w
);

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sck_o);

  // R7
  sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_w |=> $stable(sck_o));

  // R10
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_soft_en_i |-> (cs_o == !busy_o));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_w || shift_w) |=> ($stable(mosi_o) && $stable(dcx_o)));

  // R3
  dc_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !accept_w && mode_q_w == LM_DC_ONE) |=> $stable(dcx_o));

  // R2
  dc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q_w == LM_A0_ONE) |-> !dcx_o);

  // R12
  ready_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> (!busy_o || last_w));

endmodule

bind panel_ser_tx panel_ser_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .sck_o        (sck_o),
  .cs_o         (cs_o),
  .mosi_o       (mosi_o),
  .dcx_o        (dcx_o),
  .cs_soft_en_i (cs_soft_en_i),
  .word_ready_o (word_ready_o),
  .tick_w       (tick_w),
  .accept_w     (accept_w),
  .shift_w      (shift_w),
  .last_w       (last_w),
  .mode_q_w     (mode_q_w)
);

// File: tb/panel_ser_tx_tb.sv
`timescale 1ns/1ps
module panel_ser_tx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [4:0]  size_i = 5'h07;
  logic [1:0]  mode_i = 2'd1;
  logic        dc_i = 1'b0;
  logic [2:0]  baud_i = '0;
  logic        cs_soft_en_i = 1'b0;
  logic        cs_soft_lvl_i = 1'b1;
  logic        sck_o, mosi_o, dcx_o, cs_o, busy_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  panel_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .size_i(size_i), .mode_i(mode_i), .dc_i(dc_i),
    .baud_i(baud_i), .cs_soft_en_i(cs_soft_en_i), .cs_soft_lvl_i(cs_soft_lvl_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .dcx_o(dcx_o), .cs_o(cs_o), .busy_o(busy_o)
  );

  // Line monitor, sampling between clock edges
  bit cap_m [0:4095];
  bit cap_d [0:4095];
  int ncap = 0;
  int cyc = 0;
  int t_brise, t_bfall, t_cfall, t_crise, t_ffall, t_frise, t_lrise;
  int cs_falls = 0, cs_rises = 0, viol = 0;
  bit want_fall = 0, want_rise = 0;
  bit p_busy = 0, p_cs = 1, p_sck = 1, p_m = 0, p_d = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!p_busy && busy_o) begin t_brise = cyc; want_fall = 1; end
      if (p_busy && !busy_o) t_bfall = cyc;
      if (p_cs && !cs_o) begin t_cfall = cyc; cs_falls++; end
      if (!p_cs && cs_o) begin t_crise = cyc; cs_rises++; end
      if (p_sck && !sck_o && want_fall) begin
        t_ffall = cyc; want_fall = 0; want_rise = 1;
      end
      if (!p_sck && sck_o && busy_o) begin
        if (ncap < 4096) begin cap_m[ncap] = mosi_o; cap_d[ncap] = dcx_o; end
        ncap++;
        t_lrise = cyc;
        if (want_rise) begin t_frise = cyc; want_rise = 0; end
      end
      if (p_busy && busy_o && (p_sck == sck_o) && ((mosi_o != p_m) || (dcx_o != p_d)))
        viol++;
    end
    p_busy = busy_o; p_cs = cs_o; p_sck = sck_o; p_m = mosi_o; p_d = dcx_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected behaviour, restated from the requirements
  function automatic int len_of(input logic [4:0] code);
    if (code == 5'h08) return 9;
    if (code == 5'h0F) return 16;
    if (code == 5'h11) return 18;
    if (code == 5'h17) return 24;
    return 8;
  endfunction

  function automatic int nb_of(input int mode, input int len);
    if (mode == 1) return len + 1;
    if (mode == 3) return len / 2 + 1;
    return len;
  endfunction

  function automatic bit exp_bit(input logic [31:0] w, input int mode, input int len,
                                 input bit dc, input int j, input bit on_dcx);
    logic [31:0] t;
    int h;
    h = len / 2;
    if (mode == 1) begin
      if (on_dcx) return 1'b0;
      if (j == 0) return dc;
      t = (w << (32 - len)) << (j - 1);
      return t[31];
    end
    if (mode == 3) begin
      if (j == 0) return dc;
      if (on_dcx) t = ((w >> h) << (32 - h)) << (j - 1);
      else        t = (w << (32 - h)) << (j - 1);
      return t[31];
    end
    if (on_dcx) return dc;
    t = (w << (32 - len)) << j;
    return t[31];
  endfunction

  function automatic int exp_pack(input logic [31:0] w, input int mode, input int len,
                                  input bit dc, input bit on_dcx);
    int v = 0;
    for (int j = 0; j < nb_of(mode, len); j++)
      v = (v << 1) | int'(exp_bit(w, mode, len, dc, j, on_dcx));
    return v;
  endfunction

  function automatic int cap_pack(input int base, input int n, input bit on_dcx);
    int v = 0;
    for (int j = 0; j < n; j++)
      v = (v << 1) | int'(on_dcx ? cap_d[base + j] : cap_m[base + j]);
    return v;
  endfunction

  // Offer a word; once taken, scramble every captured input (R12)
  task automatic push(input logic [23:0] w, input int mode, input logic [4:0] code,
                      input bit dc, input int br);
    @(negedge clk);
    word_i = w; mode_i = 2'(mode); size_i = code; dc_i = dc; baud_i = 3'(br);
    word_valid_i = 1'b1;
    while (!word_ready_o) @(negedge clk);
    @(negedge clk);
    word_valid_i = 1'b0;
    word_i = ~w; dc_i = ~dc; size_i = 5'h17; mode_i = ~2'(mode); baud_i = 3'd5;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic one_frame(input string req, input logic [23:0] w, input int mode,
                           input logic [4:0] code, input bit dc, input int br);
    int base, len, nb, hp;
    base = ncap; len = len_of(code); nb = nb_of(mode, len); hp = 1 << br;
    push(w, mode, code, dc, br);
    wait_idle();
    chk(ncap - base == nb, req, "clock count", ncap - base, nb);
    chk(cap_pack(base, nb, 0) == exp_pack(32'(w), mode, len, dc, 0), req, "mosi stream",
        cap_pack(base, nb, 0), exp_pack(32'(w), mode, len, dc, 0));
    chk(cap_pack(base, nb, 1) == exp_pack(32'(w), mode, len, dc, 1), req, "dcx stream",
        cap_pack(base, nb, 1), exp_pack(32'(w), mode, len, dc, 1));
    chk(t_ffall - t_brise == hp, "R7", "start to first fall", t_ffall - t_brise, hp);
    chk(t_frise - t_ffall == hp, "R7", "low half width", t_frise - t_ffall, hp);
    chk(t_bfall - t_lrise == hp, "R8", "last rise to release", t_bfall - t_lrise, hp);
    chk(sck_o == 1'b1, "R1", "sck idle", sck_o, 1);
  endtask

  task automatic t_reset();
    chk(cs_o == 1'b1, "R1", "cs after reset", cs_o, 1);
    chk(sck_o == 1'b1, "R1", "sck after reset", sck_o, 1);
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(word_ready_o == 1'b1, "R1", "ready after reset", word_ready_o, 1);
  endtask

  task automatic t_prefix_lane();
    one_frame("R2", 24'h0000A5, 1, 5'h07, 1'b1, 0);
    one_frame("R2", 24'h0001C3, 1, 5'h08, 1'b0, 1);
    one_frame("R2", 24'h9A5C3E, 1, 5'h17, 1'b1, 0);
  endtask

  task automatic t_flag_lane();
    one_frame("R3", 24'h00BEEF, 2, 5'h0F, 1'b0, 0);
    one_frame("R3", 24'h00005A, 2, 5'h07, 1'b1, 1);
    one_frame("R3", 24'h000093, 0, 5'h07, 1'b1, 0);
  endtask

  task automatic t_two_lane();
    one_frame("R4", 24'h0012C5, 3, 5'h0F, 1'b1, 0);
    one_frame("R4", 24'h02ABCD, 3, 5'h11, 1'b0, 1);
    one_frame("R4", 24'hF0A55A, 3, 5'h17, 1'b1, 0);
    one_frame("R4", 24'h00016B, 3, 5'h08, 1'b0, 0);
  endtask

  task automatic t_sizes();
    one_frame("R5", 24'h0000C6, 2, 5'h05, 1'b0, 0);
    one_frame("R5", 24'h03F0F1, 2, 5'h11, 1'b1, 0);
    one_frame("R5", 24'h0001FF, 1, 5'h1F, 1'b0, 0);
  endtask

  task automatic t_high_bits();
    one_frame("R6", 24'hFFFF12, 2, 5'h07, 1'b0, 0);
    one_frame("R6", 24'hFE0155, 1, 5'h08, 1'b1, 0);
  endtask

  task automatic t_divider();
    one_frame("R7", 24'h000069, 2, 5'h07, 1'b0, 2);
    one_frame("R7", 24'h0000B4, 1, 5'h07, 1'b1, 3);
  endtask

  task automatic t_chain();
    int base, falls0, nb, hp;
    base = ncap; falls0 = cs_falls; nb = nb_of(1, 8); hp = 2;
    push(24'h0000E1, 1, 5'h07, 1'b0, 1);
    push(24'h00003D, 1, 5'h07, 1'b1, 1);
    wait_idle();
    chk(cs_falls - falls0 == 1, "R8", "cs falls for two chained words", cs_falls - falls0, 1);
    chk(ncap - base == 2 * nb, "R8", "chained clock count", ncap - base, 2 * nb);
    chk(cap_pack(base, nb, 0) == exp_pack(32'h0E1, 1, 8, 1'b0, 0), "R8", "first word",
        cap_pack(base, nb, 0), exp_pack(32'h0E1, 1, 8, 1'b0, 0));
    chk(cap_pack(base + nb, nb, 0) == exp_pack(32'h03D, 1, 8, 1'b1, 0), "R8", "second word",
        cap_pack(base + nb, nb, 0), exp_pack(32'h03D, 1, 8, 1'b1, 0));
    chk(t_crise - t_lrise == hp, "R8", "release after last rise", t_crise - t_lrise, hp);
    chk(t_cfall == t_brise, "R10", "busy rise vs cs fall", t_brise, t_cfall);
    chk(t_crise == t_bfall, "R10", "busy fall vs cs rise", t_bfall, t_crise);
  endtask

  task automatic t_soft_cs();
    int falls0, rises0;
    @(negedge clk);
    cs_soft_en_i = 1'b1; cs_soft_lvl_i = 1'b0;
    #1;
    chk(cs_o == 1'b0, "R9", "soft low while idle", cs_o, 0);
    falls0 = cs_falls; rises0 = cs_rises;
    one_frame("R9", 24'h0000D2, 2, 5'h07, 1'b1, 1);
    chk(cs_rises == rises0 && cs_falls == falls0, "R9", "cs edges during soft frame",
        cs_rises - rises0, 0);
    chk(t_bfall > t_brise, "R10", "busy pulse in soft mode", t_bfall - t_brise, 1);
    @(negedge clk);
    cs_soft_lvl_i = 1'b1;
    #1;
    chk(cs_o == 1'b1, "R9", "soft high while idle", cs_o, 1);
    cs_soft_en_i = 1'b0;
  endtask

  task automatic t_latch();
    // push() overwrites every captured input right after the accept
    one_frame("R12", 24'h00A3C5, 3, 5'h0F, 1'b0, 1);
    chk(word_ready_o == 1'b1, "R12", "ready when idle", word_ready_o, 1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_prefix_lane();
    t_flag_lane();
    t_two_lane();
    t_sizes();
    t_high_bits();
    t_divider();
    t_chain();
    t_soft_cs();
    t_latch();
    chk(viol == 0, "R11", "line changes outside launch edges", viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule